// File: doc/BRIEF.md
# Transmitter PHY Power-Up Sequencer

This block powers up a serial video transmitter PHY. A start strobe hands it a requested pixel clock in kHz. It then steps the PHY's local control bits through a fixed power and reset choreography, and it programs the PHY's internal registers through an indirect write port. That port uses a clear, go and status handshake. The PLL words come from one table indexed by pixel clock and the output drive words from a second. At the end of each pass the block waits a bounded time for PLL lock.

The full choreography runs twice back to back. A pass that does not see lock in its window stops the run with an error, and the second pass is not started. An indirect write whose status never arrives is abandoned after its own window, and the sequence continues without flagging an error. Both windows are parameters given in milliseconds and are turned into cycle limits from the clock rate.

Top module: `phy_init_seq`

## Requirements
- R1: After reset every control output, `stat_clr`, `wr_go`, `slave_addr`, `done` and `err` are 0.
- R2: The PLL words come from the first PLL table entry whose key is greater than or equal to `pix_khz`, with an equal key counting as a match. Default keys are 45250, 92500, 148500 and all-ones, and the all-ones entry matches any request. Default words for entries 0..3 are (0x00B3,0x0000,0x0018), (0x0072,0x0001,0x0028), (0x0051,0x0002,0x0038) and (0x0040,0x0003,0x0018).
- R3: The drive words come from the second table under the same first-match rule. Default keys are 165000 and all-ones. Default words are (0x0004,0x8009,0x0232) for entry 0 and (0x0004,0x8029,0x0273) for entry 1.
- R4: Each pass issues nine indirect writes in this order. The three PLL words go to addresses 0x06, 0x15 and 0x10. Next come 0x0000 to 0x13 and 0x0006 to 0x17. The three drive words go to 0x19, 0x09 and 0x0E, and the pass ends with 0x8000 to 0x05.
- R5: Every indirect write is a one-cycle `stat_clr` followed in the very next cycle by a one-cycle `wr_go`, with `wr_addr` and `wr_data` valid while `wr_go` is high.
- R6: A write completes on the first cycle in which either bit of `wr_stat` is 1. The next write's `wr_go` then comes r+2 cycles after the previous one, where r is the number of cycles from `wr_go` to the status response.
- R7: A write that gets no status gives up after WR_TO_MS milliseconds of cycles, so the next `wr_go` comes exactly WR_CYC+2 cycles later, and no error is raised.
- R8: A successful run makes two complete passes: 18 writes and two `phy_rst` pulses, ending with `done`=1 and `err`=0.
- R9: After success the control bits are: `den_pol_sel`=1, `ifc_sel`=0, `pwr_en`=1, `tmds_en`=1, `tx_pwr_on`=1, `pddq`=0, `spare_en`=1, `aux_rst`=1, `phy_rst`=0, `test_clr`=0, and `slave_addr`=SLAVE_ADDR (default 0x69).
- R10: Lock is sampled for LOCK_CYC cycles, starting the cycle after `spare_en` is set, which is two cycles after `pddq` falls. Lock seen in the last sampled cycle passes. No lock in the window sets `err` and `done`.
- R11: A lock failure in the first pass ends the run after nine writes and one `phy_rst` pulse.
- R12: `start` is ignored while a run is in progress. A new `start` clears `done` and `err`.
- R13: Within a pass the control edges come in this order: `tmds_en` off, `pwr_en` off, `tx_pwr_on` off, `pddq` on, `phy_rst` pulse, `test_clr` high then low, the indirect writes, `pwr_en` on, `tmds_en` rise, `tx_pwr_on` on, `pddq` off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| pix_khz | input | PCLK_W | Requested pixel clock in kHz, captured at start |
| wr_stat | input | 2 | Indirect-write status, either bit meaning complete |
| pll_lock | input | 1 | PHY PLL lock indication |
| den_pol_sel | output | 1 | Data-enable polarity select |
| ifc_sel | output | 1 | Interface control select |
| tmds_en | output | 1 | Serial data output enable |
| pwr_en | output | 1 | PHY power enable |
| tx_pwr_on | output | 1 | Transmitter power on |
| pddq | output | 1 | PHY power-down |
| spare_en | output | 1 | Spare control bit |
| phy_rst | output | 1 | PHY reset pulse |
| aux_rst | output | 1 | Auxiliary PHY reset |
| test_clr | output | 1 | PHY test-clear |
| slave_addr | output | 7 | PHY serial slave address loaded in each pass |
| stat_clr | output | 1 | Clears write status before a write |
| wr_go | output | 1 | Indirect write command strobe |
| wr_addr | output | 8 | Indirect write register address |
| wr_data | output | 16 | Indirect write data word |
| done | output | 1 | Run finished, held until next start |
| err | output | 1 | Run ended without PLL lock |

## Verification
Two things can fall in the same cycle: lock arriving, and the lock window closing. The bench watches for the falling edge of `pddq` and counts cycles from there. It raises `pll_lock` for exactly one cycle, placed on the last sampled cycle of the window, in both passes, and expects a clean finish with `err` low. It then repeats the run with the pulse one cycle later and expects `err` and `done` set after nine writes. This shows that lock takes priority over expiry when both occur together, and that the second pass never starts after a failure.

// File: rtl/physeq_pkg.sv
`timescale 1ns/1ps
package physeq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WCLR,
        ST_WGO,
        ST_WWAIT,
        ST_LOCK
    } seq_st_e;

    typedef struct packed {
        logic den_pol_sel;
        logic ifc_sel;
        logic tmds_en;
        logic pwr_en;
        logic tx_pwr_on;
        logic pddq;
        logic spare_en;
        logic phy_rst;
        logic aux_rst;
        logic test_clr;
        logic slave_ld;
    } phy_ctl_t;

    localparam int STEP_W    = 5;
    localparam int FIRST_WR  = 12;
    localparam int NUM_WR    = 9;
    localparam int LAST_STEP = 26;

    function automatic logic is_wr_step(input logic [STEP_W-1:0] s);
        return (int'(s) >= FIRST_WR) && (int'(s) < FIRST_WR + NUM_WR);
    endfunction

endpackage

// File: rtl/physeq_lookup.sv
`timescale 1ns/1ps
module physeq_lookup #(
    parameter int N     = 4,
    parameter int KEY_W = 20,
    parameter int VAL_W = 48,
    parameter logic [N-1:0][KEY_W-1:0] KEYS = '1,
    parameter logic [N-1:0][VAL_W-1:0] VALS = '0
) (
    input  logic [KEY_W-1:0] key,
    output logic [VAL_W-1:0] val
);
    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            assign hit[i] = (key <= KEYS[i]);
        end
    endgenerate

    // lowest-index matching entry wins; last entry is the catch-all
    always_comb begin
        val = VALS[N-1];
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) val = VALS[i];
        end
    end
endmodule

// File: rtl/physeq_timer.sv
`timescale 1ns/1ps
module physeq_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = run ? cnt_q + 1'b1 : '0;
        expired = run && (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7 / R10: a window never runs past its limit
    assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CW'(LIMIT)));
endmodule

// File: rtl/phy_init_seq.sv
`timescale 1ns/1ps
module phy_init_seq
    import physeq_pkg::*;
#(
    parameter int PCLK_W     = 20,
    parameter int CLK_KHZ    = 200000,
    parameter int WR_TO_MS   = 1000,
    parameter int LOCK_TO_MS = 5,
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int PLL_N = 4,
    parameter int DRV_N = 2,
    parameter logic [PLL_N-1:0][PCLK_W-1:0] PLL_KEYS =
        {20'hFFFFF, 20'd148500, 20'd92500, 20'd45250},
    parameter logic [PLL_N-1:0][47:0] PLL_VALS =
        {48'h0018_0003_0040, 48'h0038_0002_0051, 48'h0028_0001_0072, 48'h0018_0000_00B3},
    parameter logic [DRV_N-1:0][PCLK_W-1:0] DRV_KEYS = {20'hFFFFF, 20'd165000},
    parameter logic [DRV_N-1:0][47:0] DRV_VALS =
        {48'h0273_8029_0004, 48'h0232_8009_0004},
    parameter logic [7:0] A_CPCE = 8'h06,
    parameter logic [7:0] A_GMP  = 8'h15,
    parameter logic [7:0] A_CURR = 8'h10,
    parameter logic [7:0] A_BYP  = 8'h13,
    parameter logic [7:0] A_BIST = 8'h17,
    parameter logic [7:0] A_TERM = 8'h19,
    parameter logic [7:0] A_SYM  = 8'h09,
    parameter logic [7:0] A_VLEV = 8'h0E,
    parameter logic [7:0] A_CAL  = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PCLK_W-1:0] pix_khz,
    input  logic [1:0]        wr_stat,
    input  logic              pll_lock,
    output logic              den_pol_sel,
    output logic              ifc_sel,
    output logic              tmds_en,
    output logic              pwr_en,
    output logic              tx_pwr_on,
    output logic              pddq,
    output logic              spare_en,
    output logic              phy_rst,
    output logic              aux_rst,
    output logic              test_clr,
    output logic [6:0]        slave_addr,
    output logic              stat_clr,
    output logic              wr_go,
    output logic [7:0]        wr_addr,
    output logic [15:0]       wr_data,
    output logic              done,
    output logic              err
);
    localparam int WR_CYC   = CLK_KHZ * WR_TO_MS;
    localparam int LOCK_CYC = CLK_KHZ * LOCK_TO_MS;

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic              pass;
        logic [PCLK_W-1:0] pix;
        phy_ctl_t          ctl;
        logic              done;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;
    logic [47:0] pll_w, drv_w;
    logic wr_exp, lock_exp;
    logic [STEP_W-1:0] nxt_step, wr_idx;

    physeq_lookup #(.N(PLL_N), .KEY_W(PCLK_W), .VAL_W(48),
                    .KEYS(PLL_KEYS), .VALS(PLL_VALS)) u_pll_tab (
        .key(s_q.pix), .val(pll_w));

    physeq_lookup #(.N(DRV_N), .KEY_W(PCLK_W), .VAL_W(48),
                    .KEYS(DRV_KEYS), .VALS(DRV_VALS)) u_drv_tab (
        .key(s_q.pix), .val(drv_w));

    physeq_timer #(.LIMIT(WR_CYC)) u_wr_tmr (
        .clk(clk), .rst_n(rst_n), .run(s_q.st == ST_WWAIT), .expired(wr_exp));

    physeq_timer #(.LIMIT(LOCK_CYC)) u_lock_tmr (
        .clk(clk), .rst_n(rst_n), .run(s_q.st == ST_LOCK), .expired(lock_exp));

    assign nxt_step = s_q.step + 5'd1;
    assign wr_idx   = s_q.step - 5'(FIRST_WR);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_CTRL;
                    s_d.step = '0;
                    s_d.pass = 1'b0;
                    s_d.pix  = pix_khz;
                    s_d.done = 1'b0;
                    s_d.err  = 1'b0;
                end
            end
            ST_CTRL: begin
                case (s_q.step)
                    5'd0:  s_d.ctl.den_pol_sel = 1'b1;
                    5'd1:  s_d.ctl.ifc_sel     = 1'b0;
                    5'd2:  s_d.ctl.tmds_en     = 1'b0;
                    5'd3:  s_d.ctl.pwr_en      = 1'b0;
                    5'd4:  s_d.ctl.tx_pwr_on   = 1'b0;
                    5'd5:  s_d.ctl.pddq        = 1'b1;
                    5'd6:  s_d.ctl.phy_rst     = 1'b1;
                    5'd7:  s_d.ctl.phy_rst     = 1'b0;
                    5'd8:  s_d.ctl.aux_rst     = 1'b1;
                    5'd9:  s_d.ctl.test_clr    = 1'b1;
                    5'd10: s_d.ctl.slave_ld    = 1'b1;
                    5'd11: s_d.ctl.test_clr    = 1'b0;
                    5'd21: s_d.ctl.pwr_en      = 1'b1;
                    5'd22: s_d.ctl.tmds_en     = 1'b0;
                    5'd23: s_d.ctl.tmds_en     = 1'b1;
                    5'd24: s_d.ctl.tx_pwr_on   = 1'b1;
                    5'd25: s_d.ctl.pddq        = 1'b0;
                    5'd26: s_d.ctl.spare_en    = 1'b1;
                    default: ;
                endcase
                if (int'(s_q.step) == LAST_STEP) begin
                    s_d.st = ST_LOCK;
                end else begin
                    s_d.step = nxt_step;
                    s_d.st   = is_wr_step(nxt_step) ? ST_WCLR : ST_CTRL;
                end
            end
            ST_WCLR: s_d.st = ST_WGO;
            ST_WGO:  s_d.st = ST_WWAIT;
            ST_WWAIT: begin
                // completion or give-up both move on; give-up is not an error
                if ((|wr_stat) || wr_exp) begin
                    s_d.step = nxt_step;
                    s_d.st   = is_wr_step(nxt_step) ? ST_WCLR : ST_CTRL;
                end
            end
            ST_LOCK: begin
                if (pll_lock) begin
                    if (!s_q.pass) begin
                        s_d.pass = 1'b1;
                        s_d.step = '0;
                        s_d.st   = ST_CTRL;
                    end else begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end
                end else if (lock_exp) begin
                    s_d.err  = 1'b1;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        wr_addr = '0;
        wr_data = '0;
        case (wr_idx)
            5'd0: begin wr_addr = A_CPCE; wr_data = pll_w[15:0];  end
            5'd1: begin wr_addr = A_GMP;  wr_data = pll_w[31:16]; end
            5'd2: begin wr_addr = A_CURR; wr_data = pll_w[47:32]; end
            5'd3: begin wr_addr = A_BYP;  wr_data = 16'h0000;     end
            5'd4: begin wr_addr = A_BIST; wr_data = 16'h0006;     end
            5'd5: begin wr_addr = A_TERM; wr_data = drv_w[15:0];  end
            5'd6: begin wr_addr = A_SYM;  wr_data = drv_w[31:16]; end
            5'd7: begin wr_addr = A_VLEV; wr_data = drv_w[47:32]; end
            5'd8: begin wr_addr = A_CAL;  wr_data = 16'h8000;     end
            default: ;
        endcase
    end

    assign den_pol_sel = s_q.ctl.den_pol_sel;
    assign ifc_sel     = s_q.ctl.ifc_sel;
    assign tmds_en     = s_q.ctl.tmds_en;
    assign pwr_en      = s_q.ctl.pwr_en;
    assign tx_pwr_on   = s_q.ctl.tx_pwr_on;
    assign pddq        = s_q.ctl.pddq;
    assign spare_en    = s_q.ctl.spare_en;
    assign phy_rst     = s_q.ctl.phy_rst;
    assign aux_rst     = s_q.ctl.aux_rst;
    assign test_clr    = s_q.ctl.test_clr;
    assign slave_addr  = s_q.ctl.slave_ld ? SLAVE_ADDR : 7'd0;
    assign stat_clr    = (s_q.st == ST_WCLR);
    assign wr_go       = (s_q.st == ST_WGO);
    assign done        = s_q.done;
    assign err         = s_q.err;

    assert_go_after_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> $past(stat_clr));

    assert_err_sets_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    assert_lock_beats_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_LOCK && pll_lock) |=> !err);

    assert_tmds_needs_power_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmds_en) |-> pwr_en);

    assert_pddq_after_txpwr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pddq) |-> tx_pwr_on);
endmodule

// File: tb/tb_phy_init_seq.sv
`timescale 1ns/1ps
module tb_phy_init_seq;
    localparam int CLK_KHZ  = 4;
    localparam int WR_MS    = 1000;
    localparam int LOCK_MS  = 5;
    localparam int WR_CYC   = CLK_KHZ * WR_MS;
    localparam int LOCK_CYC = CLK_KHZ * LOCK_MS;

    typedef struct packed {
        logic [19:0] pix;
        logic [1:0]  code;
        logic [1:0]  pi;
        logic        di;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{20'd25175,  2'b01, 2'd0, 1'b0},
        '{20'd45250,  2'b10, 2'd0, 1'b0},
        '{20'd45251,  2'b11, 2'd1, 1'b0},
        '{20'd148500, 2'b01, 2'd2, 1'b0},
        '{20'd148501, 2'b10, 2'd3, 1'b0},
        '{20'd165001, 2'b01, 2'd3, 1'b1},
        '{20'd300000, 2'b11, 2'd3, 1'b1}
    };

    localparam logic [7:0]  EXP_A [9] = '{8'h06, 8'h15, 8'h10, 8'h13, 8'h17, 8'h19, 8'h09, 8'h0E, 8'h05};
    localparam logic [15:0] P_CP  [4] = '{16'h00B3, 16'h0072, 16'h0051, 16'h0040};
    localparam logic [15:0] P_GM  [4] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003};
    localparam logic [15:0] P_CU  [4] = '{16'h0018, 16'h0028, 16'h0038, 16'h0018};
    localparam logic [15:0] D_TE  [2] = '{16'h0004, 16'h0004};
    localparam logic [15:0] D_SY  [2] = '{16'h8009, 16'h8029};
    localparam logic [15:0] D_VL  [2] = '{16'h0232, 16'h0273};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pll_lock = 1'b0;
    logic [19:0] pix_khz = '0;
    logic [1:0]  wr_stat = 2'b00;
    logic den_pol_sel, ifc_sel, tmds_en, pwr_en, tx_pwr_on, pddq, spare_en;
    logic phy_rst, aux_rst, test_clr, stat_clr, wr_go, done, err;
    logic [6:0]  slave_addr;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;

    phy_init_seq #(.CLK_KHZ(CLK_KHZ), .WR_TO_MS(WR_MS), .LOCK_TO_MS(LOCK_MS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz),
        .wr_stat(wr_stat), .pll_lock(pll_lock),
        .den_pol_sel(den_pol_sel), .ifc_sel(ifc_sel), .tmds_en(tmds_en),
        .pwr_en(pwr_en), .tx_pwr_on(tx_pwr_on), .pddq(pddq), .spare_en(spare_en),
        .phy_rst(phy_rst), .aux_rst(aux_rst), .test_clr(test_clr),
        .slave_addr(slave_addr), .stat_clr(stat_clr), .wr_go(wr_go),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err));

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    longint cyc = 0;
    int nwr = 0, nrst = 0, r5_bad = 0;
    logic [7:0]  wa [64];
    logic [15:0] wd [64];
    longint      wt [64];
    longint      ev [13];
    logic [1:0]  resp_code = 2'b01;
    bit drop_first = 0, dropped = 0;
    int lock_mode = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_data(input int j, input int pi, input int di);
        case (j)
            0: return P_CP[pi];
            1: return P_GM[pi];
            2: return P_CU[pi];
            3: return 16'h0000;
            4: return 16'h0006;
            5: return D_TE[di];
            6: return D_SY[di];
            7: return D_VL[di];
            default: return 16'h8000;
        endcase
    endfunction

    // observer
    initial begin
        logic p_clr, p_tm, p_pw, p_tx, p_pd, p_rs, p_tc;
        p_clr = 0; p_tm = 0; p_pw = 0; p_tx = 0; p_pd = 0; p_rs = 0; p_tc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (wr_go) begin
                if (nwr < 64) begin
                    wa[nwr] = wr_addr; wd[nwr] = wr_data; wt[nwr] = cyc;
                end
                if (!p_clr) r5_bad++;
                nwr++;
            end
            if (p_tm && !tmds_en)   ev[0]  = cyc;
            if (p_pw && !pwr_en)    ev[1]  = cyc;
            if (p_tx && !tx_pwr_on) ev[2]  = cyc;
            if (!p_pd && pddq)      ev[3]  = cyc;
            if (!p_rs && phy_rst) begin ev[4] = cyc; nrst++; end
            if (p_rs && !phy_rst)   ev[5]  = cyc;
            if (!p_tc && test_clr)  ev[6]  = cyc;
            if (p_tc && !test_clr)  ev[7]  = cyc;
            if (!p_pw && pwr_en)    ev[9]  = cyc;
            if (!p_tm && tmds_en)   ev[10] = cyc;
            if (!p_tx && tx_pwr_on) ev[11] = cyc;
            if (p_pd && !pddq)      ev[12] = cyc;
            p_clr = stat_clr; p_tm = tmds_en; p_pw = pwr_en; p_tx = tx_pwr_on;
            p_pd = pddq; p_rs = phy_rst; p_tc = test_clr;
        end
    end

    // indirect-write responder: status one cycle after the command
    initial begin
        forever begin
            @(negedge clk);
            if (wr_go) begin
                if (drop_first && !dropped) begin
                    dropped = 1;
                end else begin
                    @(negedge clk);
                    wr_stat = resp_code;
                    @(negedge clk);
                    wr_stat = 2'b00;
                end
            end
        end
    end

    // lock driver: one-cycle lock pulse placed relative to the pddq release
    initial begin
        logic p_pd;
        p_pd = 0;
        forever begin
            @(negedge clk);
            if (lock_mode != 0 && p_pd && !pddq) begin
                repeat (lock_mode == 1 ? LOCK_CYC : LOCK_CYC + 1) @(negedge clk);
                pll_lock = 1'b1;
                @(negedge clk);
                pll_lock = 1'b0;
            end
            p_pd = pddq;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic kick(input logic [19:0] pix, input logic [1:0] code,
                        input int lmode, input bit drop);
        nwr = 0; nrst = 0; r5_bad = 0;
        resp_code = code; drop_first = drop; dropped = 0;
        lock_mode = lmode; pll_lock = (lmode == 0);
        pix_khz = pix;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_run();
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_final(input string tag);
        logic [9:0] act;
        act = {den_pol_sel, ifc_sel, tmds_en, pwr_en, tx_pwr_on, pddq,
               spare_en, phy_rst, aux_rst, test_clr};
        check(act == 10'b1011101010, "R9", {tag, " control bits"}, act, 10'b1011101010);
        check(slave_addr == 7'h69, "R9", {tag, " slave address"}, slave_addr, 7'h69);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({den_pol_sel, ifc_sel, tmds_en, pwr_en, tx_pwr_on, pddq, spare_en,
               phy_rst, aux_rst, test_clr, stat_clr, wr_go, done, err} == 14'd0 &&
              slave_addr == 7'd0, "R1", "outputs in reset", {tmds_en, pddq, done}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check({den_pol_sel, pwr_en, pddq, wr_go, stat_clr, done, err} == 7'd0,
              "R1", "outputs after reset release", {pwr_en, pddq, done}, 0);

        // vector table: table lookups, write order, two passes
        for (int v = 0; v < NV; v++) begin
            int bp, bd, bf;
            kick(VECS[v].pix, VECS[v].code, 0, 0);
            finish_run();
            check(done && !err, "R8", "done without error", {done, err}, 2'b10);
            check(nwr == 18, "R8", "write count", nwr, 18);
            check(nrst == 2, "R8", "phy reset pulses", nrst, 2);
            check(r5_bad == 0, "R5", "clear precedes go", r5_bad, 0);
            bp = -1; bd = -1; bf = -1;
            for (int k = 0; k < 18 && k < nwr; k++) begin
                int j;
                logic ok;
                j = k % 9;
                ok = (wa[k] == EXP_A[j]) &&
                     (wd[k] == exp_data(j, int'(VECS[v].pi), int'(VECS[v].di)));
                if (!ok) begin
                    if (j <= 2 && bp < 0) bp = k;
                    else if (j >= 5 && j <= 7 && bd < 0) bd = k;
                    else if (bf < 0) bf = k;
                end
            end
            if (bp >= 0)
                check(0, "R2", "PLL write", {wa[bp], wd[bp]},
                      {EXP_A[bp % 9], exp_data(bp % 9, int'(VECS[v].pi), int'(VECS[v].di))});
            else check(1, "R2", "PLL writes", 0, 0);
            if (bd >= 0)
                check(0, "R3", "drive write", {wa[bd], wd[bd]},
                      {EXP_A[bd % 9], exp_data(bd % 9, int'(VECS[v].pi), int'(VECS[v].di))});
            else check(1, "R3", "drive writes", 0, 0);
            if (bf >= 0)
                check(0, "R4", "fixed write", {wa[bf], wd[bf]},
                      {EXP_A[bf % 9], exp_data(bf % 9, int'(VECS[v].pi), int'(VECS[v].di))});
            else check(1, "R4", "fixed writes", 0, 0);
            check(wt[1] - wt[0] == 3, "R6", "command spacing on status", wt[1] - wt[0], 3);
            check_final("vector");
        end

        // R13: ordering of control edges (last pass of previous run)
        begin
            int bad;
            ev[8] = wt[9];
            bad = -1;
            for (int i = 0; i < 12; i++)
                if (bad < 0 && !(ev[i] < ev[i+1])) bad = i;
            check(bad < 0, "R13", "control edge order index", bad, -1);
        end

        // R7: first write never answered
        kick(20'd74250, 2'b01, 0, 1);
        finish_run();
        check(wt[1] - wt[0] == WR_CYC + 2, "R7", "give-up spacing", wt[1] - wt[0], WR_CYC + 2);
        check(nwr == 18 && !err && done, "R7", "run continues after give-up", {nwr, err}, {18, 1'b0});

        // R10: lock on the final window cycle in both passes
        kick(20'd74250, 2'b01, 1, 0);
        finish_run();
        check(!err && nwr == 18, "R10", "lock on last cycle accepted", {err, nwr}, 18);
        check_final("late lock");

        // R10 + R11: lock one cycle too late in the first pass
        kick(20'd74250, 2'b01, 2, 0);
        finish_run();
        check(err && done, "R10", "missed lock flags", {done, err}, 2'b11);
        check(nwr == 9 && nrst == 1, "R11", "no second pass", {nwr, nrst}, {9, 1});

        // R12: start during a run is ignored; new start clears flags
        kick(20'd25175, 2'b01, 0, 0);
        while (nwr < 3) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        finish_run();
        check(nwr == 18 && nrst == 2 && !err, "R12", "restart ignored while busy", nwr, 18);
        lock_mode = 2; pll_lock = 1'b0; nwr = 0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        check(!done && !err, "R12", "start clears done", {done, err}, 0);
        finish_run();
        check(err, "R12", "error set again", err, 1);
        @(negedge clk); start = 1'b1; pll_lock = 1'b1; lock_mode = 0;
        @(negedge clk); start = 1'b0;
        check(!err && !done, "R12", "start clears err", {done, err}, 0);
        finish_run();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule